// File: doc/BRIEF.md
# Physical Register Ready-Bit Table with Writeback Bypass

This block holds one presence flag for every physical register of an out-of-order core. The issue logic reads it to learn whether the source operands of an instruction are available. Two read ports serve the two sources of one instruction. A clear port is driven at rename when a destination register is allocated. A set port is driven at writeback when a result arrives.

The set port is forwarded combinationally to both read ports. A register written back in a cycle therefore already reads as ready in that same cycle. This lets writeback, issue and rename all proceed in one cycle.

A clear is not seen by same-cycle reads: the reads return the flag as it stood before the allocation. When a set and a clear name the same register in one cycle, the clear decides the stored value, because the allocation is the younger event. The number of registers is two to the power of the index width. After reset, the lowest `ARCH_REGS` registers are ready and all others are not.

Top module: `rdy_table`

## Requirements
- R1: While reset is asserted and right after it is released, registers with index below ARCH_REGS (32 by default, out of 64) read as ready (1) and all others read as not ready (0).
- R2: The two read ports are independent: each returns the flag of the index on its own port in the same cycle, with no register stage.
- R3: A set of register k, without a clear of k in the same cycle, makes k read as ready from the next cycle on, and k stays ready until it is cleared.
- R4: A set of register k makes k read as ready on both read ports in the same cycle as the set.
- R5: A clear of register k makes k read as not ready from the next cycle on, until it is set again.
- R6: A clear of register k does not change what the read ports return for k in the same cycle.
- R7: When a set and a clear name the same register in one cycle, the reads in that cycle return ready, and from the next cycle the register reads as not ready.
- R8: A set and a clear naming different registers in one cycle both take effect.
- R9: Registers named by neither a set nor a clear keep their flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_set_vld | input | 1 | Writeback marks a register ready |
| wb_set_idx | input | IDX_W | Register marked ready |
| ren_clr_vld | input | 1 | Rename marks a newly allocated register not ready |
| ren_clr_idx | input | IDX_W | Register marked not ready |
| src0_idx | input | IDX_W | Index looked up by read port 0 |
| src0_rdy | output | 1 | Ready flag for src0_idx, including a same-cycle set |
| src1_idx | input | IDX_W | Index looked up by read port 1 |
| src1_rdy | output | 1 | Ready flag for src1_idx, including a same-cycle set |

## Verification
Writeback and rename can both hit one cycle, and they can name the same register. The bench provokes this in three forms. In the first, a set of a register is read back in the same cycle. In the second, a clear of a register is read in its own cycle. In the third, a set and a clear name one register together.

In each case the bench judges two things. It samples the read ports combinationally in the cycle of the event. It then samples them again after the next clock edge. The read-back must show that the set is forwarded, that the clear is hidden until the edge, and that the clear wins in the stored value.

// File: rtl/rdy_pkg.sv
// Shared helpers for the ready-bit table.
// Assumes: the index width is small enough that 2**IDX_W entries fit in flops.
package rdy_pkg;

    // Reset value of one entry: registers holding architectural state start ready.
    function automatic logic reset_flag(input int unsigned entry, input int unsigned arch_regs);
        return (entry < arch_regs);
    endfunction

endpackage

// File: rtl/rdy_store.sv
// Flop array holding one ready flag per physical register.
// Applies one set and one clear per cycle; a clear of the same entry
// overrides a set. Assumes the caller handles any read forwarding.
module rdy_store #(
    parameter int unsigned IDX_W     = 6,
    parameter int unsigned ARCH_REGS = 32,
    localparam int unsigned ENTRIES  = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_vld,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic               clr_vld,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [ENTRIES-1:0] flags
);
    import rdy_pkg::*;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic set_hit;
        logic clr_hit;

        // Decode whether this entry is named by either update port.
        always_comb begin
            set_hit = set_vld && (set_idx == IDX_W'(e));
            clr_hit = clr_vld && (clr_idx == IDX_W'(e));
        end

        // Update the flag: the clear is the younger event and takes priority.
        always_ff @(posedge clk) begin
            if (!rst_n)       flags[e] <= reset_flag(e, ARCH_REGS);
            else if (clr_hit) flags[e] <= 1'b0;
            else if (set_hit) flags[e] <= 1'b1;
        end
    end

endmodule

// File: rtl/rdy_read_port.sv
// One lookup port of the ready table.
// Returns the stored flag, or ready if the same register is being set this
// cycle. A same-cycle clear is deliberately not visible here.
module rdy_read_port #(
    parameter int unsigned IDX_W    = 6,
    localparam int unsigned ENTRIES = 1 << IDX_W
) (
    input  logic [ENTRIES-1:0] flags,
    input  logic               set_vld,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_rdy
);
    // Combine the stored flag with the forwarded writeback.
    always_comb begin
        rd_rdy = flags[rd_idx] | (set_vld && (set_idx == rd_idx));
    end

endmodule

// File: rtl/rdy_table.sv
// Ready-bit table for physical registers with two source lookups,
// a rename-time clear and a writeback-time set that is forwarded to
// the lookups in its own cycle. Assumes at most one set and one clear
// per cycle; the clear wins when both name the same register.
module rdy_table #(
    parameter int unsigned IDX_W     = 6,
    parameter int unsigned ARCH_REGS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_set_vld,
    input  logic [IDX_W-1:0] wb_set_idx,
    input  logic             ren_clr_vld,
    input  logic [IDX_W-1:0] ren_clr_idx,
    input  logic [IDX_W-1:0] src0_idx,
    output logic             src0_rdy,
    input  logic [IDX_W-1:0] src1_idx,
    output logic             src1_rdy
);
    localparam int unsigned ENTRIES = 1 << IDX_W;
    localparam int unsigned PORTS   = 2;

    logic [ENTRIES-1:0]       flags;
    logic [PORTS-1:0][IDX_W-1:0] rd_idx;
    logic [PORTS-1:0]         rd_rdy;

    rdy_store #(.IDX_W(IDX_W), .ARCH_REGS(ARCH_REGS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vld (wb_set_vld),
        .set_idx (wb_set_idx),
        .clr_vld (ren_clr_vld),
        .clr_idx (ren_clr_idx),
        .flags   (flags)
    );

    // Gather the lookup indices into one vector for the port array.
    always_comb begin
        rd_idx[0] = src0_idx;
        rd_idx[1] = src1_idx;
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        rdy_read_port #(.IDX_W(IDX_W)) u_rd (
            .flags   (flags),
            .set_vld (wb_set_vld),
            .set_idx (wb_set_idx),
            .rd_idx  (rd_idx[p]),
            .rd_rdy  (rd_rdy[p])
        );
    end

    // Drive the per-source outputs from the port array.
    always_comb begin
        src0_rdy = rd_rdy[0];
        src1_rdy = rd_rdy[1];
    end

endmodule

// File: rtl/rdy_table_chk.sv
// Port-level checker for rdy_table, bound to every instance.
module rdy_table_chk #(
    parameter int unsigned IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wb_set_vld,
    input logic [IDX_W-1:0] wb_set_idx,
    input logic             ren_clr_vld,
    input logic [IDX_W-1:0] ren_clr_idx,
    input logic [IDX_W-1:0] src0_idx,
    input logic             src0_rdy,
    input logic [IDX_W-1:0] src1_idx,
    input logic             src1_rdy
);
    p_fwd_port0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_set_vld && wb_set_idx == src0_idx) |-> src0_rdy);

    p_fwd_port1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_set_vld && wb_set_idx == src1_idx) |-> src1_rdy);

    p_set_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_set_vld && !(ren_clr_vld && ren_clr_idx == wb_set_idx))
        |=> ((src0_idx == $past(wb_set_idx)) -> src0_rdy));

    p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ren_clr_vld
        |=> (((src0_idx == $past(ren_clr_idx)) && !(wb_set_vld && wb_set_idx == src0_idx)) -> !src0_rdy));

    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_clr_vld && wb_set_vld && ren_clr_idx == wb_set_idx)
        |=> (((src1_idx == $past(ren_clr_idx)) && !(wb_set_vld && wb_set_idx == src1_idx)) -> !src1_rdy));

endmodule

bind rdy_table rdy_table_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wb_set_vld  (wb_set_vld),
    .wb_set_idx  (wb_set_idx),
    .ren_clr_vld (ren_clr_vld),
    .ren_clr_idx (ren_clr_idx),
    .src0_idx    (src0_idx),
    .src0_rdy    (src0_rdy),
    .src1_idx    (src1_idx),
    .src1_rdy    (src1_rdy)
);

// File: tb/tb_rdy_table.sv
module tb_rdy_table;
    localparam int unsigned IDX_W = 6;
    localparam int unsigned ARCH  = 32;
    localparam int unsigned NREG  = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wb_set_vld = 1'b0;
    logic [IDX_W-1:0] wb_set_idx = '0;
    logic             ren_clr_vld = 1'b0;
    logic [IDX_W-1:0] ren_clr_idx = '0;
    logic [IDX_W-1:0] src0_idx = '0;
    logic [IDX_W-1:0] src1_idx = '0;
    logic             src0_rdy;
    logic             src1_rdy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    rdy_table #(.IDX_W(IDX_W), .ARCH_REGS(ARCH)) dut (
        .clk(clk), .rst_n(rst_n),
        .wb_set_vld(wb_set_vld), .wb_set_idx(wb_set_idx),
        .ren_clr_vld(ren_clr_vld), .ren_clr_idx(ren_clr_idx),
        .src0_idx(src0_idx), .src0_rdy(src0_rdy),
        .src1_idx(src1_idx), .src1_rdy(src1_rdy)
    );

    always #5 clk = ~clk;

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus at the falling edge; results settle 1 ns later.
    task automatic drive(input logic sv, input int si, input logic cv, input int ci,
                         input int r0, input int r1);
        @(negedge clk);
        wb_set_vld  = sv;  wb_set_idx  = IDX_W'(si);
        ren_clr_vld = cv;  ren_clr_idx = IDX_W'(ci);
        src0_idx    = IDX_W'(r0);
        src1_idx    = IDX_W'(r1);
        #1;
    endtask

    task automatic idle_read(input int r0, input int r1);
        drive(1'b0, 0, 1'b0, 0, r0, r1);
    endtask

    task automatic t_reset_r1();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        for (int i = 0; i < NREG; i += 2) begin
            idle_read(i, i + 1);
            check(src0_rdy, (i < ARCH), "R1");
            check(src1_rdy, ((i + 1) < ARCH), "R1");
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle_read(ARCH - 1, ARCH);
        check(src0_rdy, 1'b1, "R1");
        check(src1_rdy, 1'b0, "R1");
    endtask

    task automatic t_two_ports_r2();
        idle_read(3, 40);
        check(src0_rdy, 1'b1, "R2");
        check(src1_rdy, 1'b0, "R2");
        idle_read(40, 3);
        check(src0_rdy, 1'b0, "R2");
        check(src1_rdy, 1'b1, "R2");
    endtask

    task automatic t_set_r4_r3();
        drive(1'b1, 40, 1'b0, 0, 40, 40);
        check(src0_rdy, 1'b1, "R4");
        check(src1_rdy, 1'b1, "R4");
        idle_read(40, 41);
        check(src0_rdy, 1'b1, "R3");
        check(src1_rdy, 1'b0, "R3");
        idle_read(41, 40);
        check(src1_rdy, 1'b1, "R3");
    endtask

    task automatic t_clear_r6_r5();
        drive(1'b0, 0, 1'b1, 40, 40, 40);
        check(src0_rdy, 1'b1, "R6");
        check(src1_rdy, 1'b1, "R6");
        idle_read(40, 40);
        check(src0_rdy, 1'b0, "R5");
        check(src1_rdy, 1'b0, "R5");
        idle_read(40, 0);
        check(src0_rdy, 1'b0, "R5");
    endtask

    task automatic t_collide_r7();
        drive(1'b1, 50, 1'b1, 50, 50, 50);
        check(src0_rdy, 1'b1, "R7");
        check(src1_rdy, 1'b1, "R7");
        idle_read(50, 50);
        check(src0_rdy, 1'b0, "R7");
        check(src1_rdy, 1'b0, "R7");
        drive(1'b1, 5, 1'b1, 5, 5, 6);
        idle_read(5, 6);
        check(src0_rdy, 1'b0, "R7");
        check(src1_rdy, 1'b1, "R9");
    endtask

    task automatic t_split_r8_r9();
        drive(1'b1, 45, 1'b1, 10, 45, 10);
        check(src0_rdy, 1'b1, "R4");
        check(src1_rdy, 1'b1, "R6");
        idle_read(45, 10);
        check(src0_rdy, 1'b1, "R8");
        check(src1_rdy, 1'b0, "R8");
        idle_read(11, 46);
        check(src0_rdy, 1'b1, "R9");
        check(src1_rdy, 1'b0, "R9");
    endtask

    initial begin
        t_reset_r1();
        t_two_ports_r2();
        t_set_r4_r3();
        t_clear_r6_r5();
        t_collide_r7();
        t_split_r8_r9();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule